// File: doc/BRIEF.md
# Cartridge Bank Mapper

This block sits on the cartridge side of an 8-bit CPU bus and turns a 64 KB CPU address space into accesses to a ROM of up to 2 MB and an optional banked external RAM. Any CPU write that lands in the lower half of the address space changes a control register, because the ROM cannot be written. CPU reads of the two 16 KB ROM windows and of the 8 KB RAM window at 0xA000–0xBFFF are translated into physical ROM and RAM addresses. The read data returned to the CPU comes from ROM, from RAM, or is the idle value 0xFF.

A 2-bit upper register does two jobs, and a mode bit decides which. In one mode it extends the switchable ROM bank only. In the other mode it also selects the RAM bank and relocates the fixed ROM window. A build-time wiring option serves multi-game boards. These boards connect the bank lines one position lower, so the low bank field loses its top bit and the upper register lands on bank bit 4.

The memory arrays are outside the block. The mapper drives their addresses and a RAM write enable, and it returns their data to the CPU.

Top module: `cart_bank_mapper`

## Requirements
- R1: A write anywhere in 0x0000–0x1FFF enables the external RAM when data bits [3:0] equal 4'hA, whatever bits [7:4] hold. Any other value in those bits disables it.
- R2: A write in 0x2000–0x3FFF loads the low bank field from data bits [4:0]. A value of 0 is first turned into 1, and the result is then ANDed with the wiring mask (0x1F standard, 0x0F collection).
- R3: A write in 0x4000–0x5FFF loads the 2-bit upper register from data bits [1:0]. Data bits [7:2] are ignored.
- R4: A write in 0x6000–0x7FFF sets the mode from data bit 0: 0 means large ROM / small RAM and 1 means small ROM / large RAM. Reset selects mode 0.
- R5: Reads in 0x0000–0x3FFF use ROM bank 0 in mode 0. In mode 1 they use the upper register shifted left by 5 (standard wiring) or by 4 (collection wiring). The in-bank offset is address bits [13:0].
- R6: Reads in 0x4000–0x7FFF use bank (upper << 5) | low with standard wiring and (upper << 4) | low with collection wiring, in both modes.
- R7: The RAM window 0xA000–0xBFFF maps 8 KB per bank. The RAM bank is the upper register in mode 1 and 0 in mode 0. The RAM address is {bank, address[12:0]}.
- R8: While the RAM is disabled or not fitted, reads of the RAM window return 0xFF, and writes to it do not assert the RAM write enable and leave the RAM contents unchanged.
- R9: Collection wiring: a write of 0x10 to the low bank field selects bank 0 for the switchable window.
- R10: After reset, the low bank field is 1, the upper register is 0 and the RAM is disabled.
- R11: The ROM bank number is wrapped to ROM_BANKS banks, and the RAM bank number to RAM_BANKS banks. rom_addr is {bank, offset}.
- R12: A control write takes effect on the clock edge where cpu_wr is high. A read in the following cycle is translated with the new state.
- R13: In the ROM windows cpu_rdata returns rom_rdata. Reads outside both the ROM and RAM windows return 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_wr | input | 1 | CPU write strobe, one cycle per write |
| cpu_rdata | output | 8 | Read data returned to the CPU |
| rom_addr | output | 14+log2(ROM_BANKS) | Physical ROM byte address |
| rom_rdata | input | 8 | ROM data at rom_addr |
| ram_addr | output | 13+max(1,log2(RAM_BANKS)) | Physical RAM byte address |
| ram_we | output | 1 | RAM write enable |
| ram_rdata | input | 8 | RAM data at ram_addr |

## Verification
The bench checks how the zero-to-one substitution interacts with the collection mask. A design that masks before substituting would map a 0x10 write to bank 1 instead of bank 0. It also checks that the fixed window moves only in mode 1. A design that ignores the mode would read the wrong game's first bank. RAM gating is checked by writing while the RAM is disabled and reading the location back after enabling it again, which catches a write enable that leaks through. Address wrapping on a smaller collection build shows whether bank bits above the fitted size are dropped, and random register traffic covers the shared use of the upper register.

// File: rtl/mbc_pkg.sv
package mbc_pkg;
   localparam int unsigned LOW_W     = 5;
   localparam int unsigned UP_W      = 2;
   localparam int unsigned BANK_W    = 7;
   localparam int unsigned ROM_OFF_W = 14;
   localparam int unsigned RAM_OFF_W = 13;

   typedef enum logic {
      MAP_BIG_ROM = 1'b0,
      MAP_BIG_RAM = 1'b1
   } map_mode_e;

   typedef enum logic [1:0] {
      SEL_RAM_EN = 2'd0,
      SEL_LOW    = 2'd1,
      SEL_UP     = 2'd2,
      SEL_MODE   = 2'd3
   } ctrl_sel_e;

   typedef struct packed {
      logic             ram_en;
      logic [LOW_W-1:0] low;
      logic [UP_W-1:0]  up;
      map_mode_e        mode;
   } mbc_state_t;

   function automatic logic [LOW_W-1:0] low_mask(input bit collection);
      return collection ? 5'h0F : 5'h1F;
   endfunction
endpackage

// File: rtl/mbc_regs.sv
module mbc_regs
   import mbc_pkg::*;
#(
   parameter bit COLLECTION = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  logic [1:0] sel,
   input  logic [7:0] wdata,
   output mbc_state_t state
);
   localparam logic [LOW_W-1:0] LMASK = low_mask(COLLECTION);

   logic [LOW_W-1:0] low_nz;
   logic             unused_wdata;

   assign low_nz       = (wdata[LOW_W-1:0] == '0) ? LOW_W'(1) : wdata[LOW_W-1:0];
   assign unused_wdata = ^wdata[7:LOW_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state.ram_en <= 1'b0;
         state.low    <= LOW_W'(1);
         state.up     <= '0;
         state.mode   <= MAP_BIG_ROM;
      end else if (wr_en) begin
         case (ctrl_sel_e'(sel))
            SEL_RAM_EN: state.ram_en <= (wdata[3:0] == 4'hA);
            SEL_LOW:    state.low    <= low_nz & LMASK;
            SEL_UP:     state.up     <= wdata[UP_W-1:0];
            SEL_MODE:   state.mode   <= map_mode_e'(wdata[0]);
            default:    state.mode   <= state.mode;
         endcase
      end
   end

   p_ram_en_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && sel == 2'd0 && wdata[3:0] == 4'hA) |=> state.ram_en);
   p_ram_en_clr_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && sel == 2'd0 && wdata[3:0] != 4'hA) |=> !state.ram_en);
   p_up_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && sel == 2'd2) |=> $stable(state.up));
   p_mode_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && sel == 2'd3) |=> $stable(state.mode));
   p_low_masked_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (state.low & ~LMASK) == '0);
endmodule

// File: rtl/mbc_rom_xlate.sv
module mbc_rom_xlate
   import mbc_pkg::*;
#(
   parameter int unsigned ROM_BANKS  = 128,
   parameter bit          COLLECTION = 1'b0,
   localparam int unsigned ROM_BW    = $clog2(ROM_BANKS),
   localparam int unsigned ROM_AW    = ROM_BW + ROM_OFF_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  mbc_state_t        state,
   input  logic [14:0]       cpu_addr,
   output logic [ROM_AW-1:0] rom_addr
);
   logic [BANK_W-1:0] hi_bank;
   logic [BANK_W-1:0] fixed_bank;
   logic [BANK_W-1:0] pick;

   generate
      if (COLLECTION) begin : g_col
         assign hi_bank    = {1'b0, state.up, state.low[3:0]};
         assign fixed_bank = (state.mode == MAP_BIG_RAM) ? {1'b0, state.up, 4'b0} : '0;
      end else begin : g_std
         assign hi_bank    = {state.up, state.low};
         assign fixed_bank = (state.mode == MAP_BIG_RAM) ? {state.up, 5'b0} : '0;
      end
   endgenerate

   assign pick     = cpu_addr[14] ? hi_bank : fixed_bank;
   assign rom_addr = {pick[ROM_BW-1:0], cpu_addr[ROM_OFF_W-1:0]};

   p_fixed_bank0_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!cpu_addr[14] && state.mode == MAP_BIG_ROM) |-> rom_addr[ROM_AW-1:ROM_OFF_W] == '0);
   p_offset_pass_r11: assert property (@(posedge clk) disable iff (!rst_n)
      rom_addr[ROM_OFF_W-1:0] == cpu_addr[ROM_OFF_W-1:0]);
endmodule

// File: rtl/mbc_ram_gate.sv
module mbc_ram_gate
   import mbc_pkg::*;
#(
   parameter int unsigned RAM_BANKS = 4,
   localparam int unsigned RAM_BW   = (RAM_BANKS > 1) ? $clog2(RAM_BANKS) : 1,
   localparam int unsigned RAM_AW   = RAM_BW + RAM_OFF_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  mbc_state_t        state,
   input  logic [15:0]       cpu_addr,
   input  logic              cpu_wr,
   input  logic [7:0]        ram_rdata,
   output logic [RAM_AW-1:0] ram_addr,
   output logic              ram_we,
   output logic              ram_win,
   output logic [7:0]        ram_dout
);
   logic              usable;
   logic [UP_W-1:0]   bank_sel;
   logic [RAM_BW-1:0] bank;

   assign ram_win  = (cpu_addr[15:13] == 3'b101);
   assign bank_sel = (state.mode == MAP_BIG_RAM) ? state.up : '0;

   generate
      if (RAM_BANKS == 0) begin : g_none
         assign usable = 1'b0;
         assign bank   = '0;
      end else if (RAM_BANKS == 1) begin : g_one
         assign usable = state.ram_en;
         assign bank   = '0;
      end else begin : g_multi
         assign usable = state.ram_en;
         assign bank   = bank_sel[RAM_BW-1:0];
      end
   endgenerate

   assign ram_addr = {bank, cpu_addr[RAM_OFF_W-1:0]};
   assign ram_we   = cpu_wr && ram_win && usable;
   assign ram_dout = usable ? ram_rdata : 8'hFF;

   p_we_needs_en_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ram_we |-> state.ram_en);
   p_ram_bank0_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (state.mode == MAP_BIG_ROM) |-> ram_addr[RAM_AW-1:RAM_OFF_W] == '0);
endmodule

// File: rtl/cart_bank_mapper.sv
module cart_bank_mapper
   import mbc_pkg::*;
#(
   parameter int unsigned ROM_BANKS  = 128,
   parameter int unsigned RAM_BANKS  = 4,
   parameter bit          COLLECTION = 1'b0,
   localparam int unsigned ROM_AW    = $clog2(ROM_BANKS) + ROM_OFF_W,
   localparam int unsigned RAM_AW    = ((RAM_BANKS > 1) ? $clog2(RAM_BANKS) : 1) + RAM_OFF_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [15:0]       cpu_addr,
   input  logic [7:0]        cpu_wdata,
   input  logic              cpu_wr,
   output logic [7:0]        cpu_rdata,
   output logic [ROM_AW-1:0] rom_addr,
   input  logic [7:0]        rom_rdata,
   output logic [RAM_AW-1:0] ram_addr,
   output logic              ram_we,
   input  logic [7:0]        ram_rdata
);
   generate
      if (ROM_BANKS < 2 || ROM_BANKS > 128 || (ROM_BANKS & (ROM_BANKS - 1)) != 0) begin : g_bad_rom
         $error("ROM_BANKS must be a power of two from 2 to 128");
      end
      if (RAM_BANKS > 4 || RAM_BANKS == 3) begin : g_bad_ram
         $error("RAM_BANKS must be 0, 1, 2 or 4");
      end
   endgenerate

   mbc_state_t st;
   logic       ram_win;
   logic [7:0] ram_dout;

   mbc_regs #(.COLLECTION(COLLECTION)) u_regs (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (cpu_wr && !cpu_addr[15]),
      .sel   (cpu_addr[14:13]),
      .wdata (cpu_wdata),
      .state (st)
   );

   mbc_rom_xlate #(.ROM_BANKS(ROM_BANKS), .COLLECTION(COLLECTION)) u_rom (
      .clk      (clk),
      .rst_n    (rst_n),
      .state    (st),
      .cpu_addr (cpu_addr[14:0]),
      .rom_addr (rom_addr)
   );

   mbc_ram_gate #(.RAM_BANKS(RAM_BANKS)) u_ram (
      .clk       (clk),
      .rst_n     (rst_n),
      .state     (st),
      .cpu_addr  (cpu_addr),
      .cpu_wr    (cpu_wr),
      .ram_rdata (ram_rdata),
      .ram_addr  (ram_addr),
      .ram_we    (ram_we),
      .ram_win   (ram_win),
      .ram_dout  (ram_dout)
   );

   always_comb begin
      if (!cpu_addr[15])  cpu_rdata = rom_rdata;
      else if (ram_win)   cpu_rdata = ram_dout;
      else                cpu_rdata = 8'hFF;
   end

   p_idle_ff_r13: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_addr[15] && !ram_win) |-> cpu_rdata == 8'hFF);
   p_ram_off_ff_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ram_win && !st.ram_en) |-> cpu_rdata == 8'hFF);
endmodule

// File: tb/cart_bank_mapper_test.sv
module cart_bank_mapper_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] cpu_addr = '0;
   logic [7:0]  cpu_wdata = '0;
   logic        cpu_wr = 1'b0;

   logic [7:0]  rdata0, rdata1, romd0, romd1, ramd0, ramd1;
   logic [20:0] rom_addr0;
   logic [18:0] rom_addr1;
   logic [14:0] ram_addr0;
   logic [13:0] ram_addr1;
   logic        ram_we0, ram_we1;

   logic [7:0] mem0 [0:32767];
   logic [7:0] mem1 [0:16383];
   logic [7:0] exp0 [0:32767];
   logic [7:0] exp1 [0:16383];

   int nchk = 0;
   int nfail = 0;

   logic       m_en, m_mode;
   logic [4:0] m_low0, m_low1;
   logic [1:0] m_up;

   always #5 clk = ~clk;

   function automatic logic [7:0] romh(input logic [20:0] x);
      return x[7:0] ^ x[20:13] ^ 8'h5A;
   endfunction

   assign romd0 = romh(rom_addr0);
   assign romd1 = romh({2'b0, rom_addr1});
   assign ramd0 = mem0[ram_addr0];
   assign ramd1 = mem1[ram_addr1];

   always @(posedge clk) begin
      if (ram_we0) mem0[ram_addr0] <= cpu_wdata;
      if (ram_we1) mem1[ram_addr1] <= cpu_wdata;
   end

   cart_bank_mapper uut (
      .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
      .cpu_wr(cpu_wr), .cpu_rdata(rdata0), .rom_addr(rom_addr0), .rom_rdata(romd0),
      .ram_addr(ram_addr0), .ram_we(ram_we0), .ram_rdata(ramd0));

   cart_bank_mapper #(.ROM_BANKS(32), .RAM_BANKS(2), .COLLECTION(1'b1)) uut_col (
      .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
      .cpu_wr(cpu_wr), .cpu_rdata(rdata1), .rom_addr(rom_addr1), .rom_rdata(romd1),
      .ram_addr(ram_addr1), .ram_we(ram_we1), .ram_rdata(ramd1));

   // expected ROM bank from the requirements (R5, R6, R11)
   function automatic logic [6:0] exp_bank(input logic [15:0] a, input bit col);
      logic [6:0] b;
      if (a[14]) b = col ? {1'b0, m_up, m_low1[3:0]} : {m_up, m_low0};
      else if (m_mode) b = col ? {1'b0, m_up, 4'b0} : {m_up, 5'b0};
      else b = '0;
      return col ? (b & 7'h1F) : b;
   endfunction

   function automatic logic [4:0] exp_low(input logic [7:0] d, input bit col);
      logic [4:0] v;
      v = (d[4:0] == 5'd0) ? 5'd1 : d[4:0];
      return v & (col ? 5'h0F : 5'h1F);
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
      nchk++;
      if (act !== expv) begin
         nfail++;
         $display("FAIL %s actual=%h expected=%h", req, act, expv);
      end
   endtask

   task automatic wr(input logic [15:0] a, input logic [7:0] d);
      logic [1:0] b;
      @(negedge clk);
      cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
      @(posedge clk);
      if (!a[15]) begin
         case (a[14:13])
            2'd0: m_en = (d[3:0] == 4'hA);
            2'd1: begin m_low0 = exp_low(d, 1'b0); m_low1 = exp_low(d, 1'b1); end
            2'd2: m_up = d[1:0];
            default: m_mode = d[0];
         endcase
      end else if (a[15:13] == 3'b101 && m_en) begin
         b = m_mode ? m_up : 2'd0;
         exp0[{b, a[12:0]}] = d;
         exp1[{b[0], a[12:0]}] = d;
      end
      @(negedge clk);
      cpu_wr = 1'b0;
   endtask

   task automatic rd(input logic [15:0] a, input string req);
      logic [1:0] b;
      @(negedge clk);
      cpu_addr = a; cpu_wr = 1'b0;
      #1;
      if (!a[15]) begin
         check(req, 32'(rom_addr0), 32'({exp_bank(a, 1'b0), a[13:0]}));
         check(req, 32'(rom_addr1), 32'({exp_bank(a, 1'b1)[4:0], a[13:0]}));
         check(req, 32'(rdata0), 32'(romh(rom_addr0)));
      end else if (a[15:13] == 3'b101) begin
         b = m_mode ? m_up : 2'd0;
         check(req, 32'(rdata0), m_en ? 32'(exp0[{b, a[12:0]}]) : 32'hFF);
         check(req, 32'(rdata1), m_en ? 32'(exp1[{b[0], a[12:0]}]) : 32'hFF);
      end else begin
         check(req, 32'(rdata0), 32'hFF);
         check(req, 32'(rdata1), 32'hFF);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      nchk++; nfail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
   end

   initial begin
      for (int i = 0; i < 32768; i++) begin mem0[i] = 8'h00; exp0[i] = 8'h00; end
      for (int i = 0; i < 16384; i++) begin mem1[i] = 8'h00; exp1[i] = 8'h00; end
      m_en = 1'b0; m_mode = 1'b0; m_low0 = 5'd1; m_low1 = 5'd1; m_up = 2'd0;
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R10 reset state: low=1, up=0, RAM off; R4 mode 0
      rd(16'h4000, "R10");
      check("R10", 32'(rom_addr0), 32'({7'd1, 14'h0}));
      rd(16'h0123, "R4");
      rd(16'hA000, "R10");

      // R2 zero substitution and high bits ignored
      wr(16'h2000, 8'h00); rd(16'h4001, "R2");
      check("R2", 32'(rom_addr0[20:14]), 32'd1);
      wr(16'h3FFF, 8'hE3); rd(16'h7FFF, "R2");
      check("R2", 32'(rom_addr0[20:14]), 32'd3);

      // R9 collection: 0x10 gives bank 0, standard gives 0x10
      wr(16'h2000, 8'h10); rd(16'h4000, "R9");
      check("R9", 32'(rom_addr1[18:14]), 32'd0);
      check("R9", 32'(rom_addr0[20:14]), 32'h10);

      // R3 upper register, R6 in mode 0, R11 wrap on 32-bank collection build
      wr(16'h4000, 8'hFE); wr(16'h2000, 8'h05); rd(16'h5000, "R6");
      check("R3", 32'(rom_addr0[20:14]), 32'h45);
      check("R11", 32'(rom_addr1[18:14]), 32'h05);
      rd(16'h0000, "R5");

      // R4 and R5: mode 1 relocates the fixed window
      wr(16'h6000, 8'h01); rd(16'h1234, "R5");
      check("R5", 32'(rom_addr0[20:14]), 32'h40);
      check("R5", 32'(rom_addr1[18:14]), 32'h00);
      wr(16'h4000, 8'h01); rd(16'h0000, "R5");
      check("R5", 32'(rom_addr1[18:14]), 32'h10);

      // R1 enable variants, R7 bank select, R12 next-cycle visibility
      wr(16'h0000, 8'h1A);
      wr(16'hA010, 8'h3C); rd(16'hA010, "R1");
      check("R7", 32'(ram_addr0), 32'({2'd1, 13'h0010}));
      wr(16'h6000, 8'h00); rd(16'hA010, "R7");
      check("R7", 32'(ram_addr0[14:13]), 32'd0);
      wr(16'h4000, 8'h02); rd(16'h4000, "R12");

      // R8 writes while disabled are dropped
      wr(16'hB000, 8'h55);
      wr(16'h1000, 8'h0B); rd(16'hB000, "R8");
      wr(16'hB000, 8'hAA);
      wr(16'h1000, 8'hFA); rd(16'hB000, "R8");
      check("R8", 32'(rdata0), 32'h55);

      // R13 unmapped areas
      rd(16'h8000, "R13"); rd(16'hC000, "R13"); rd(16'hFFFF, "R13");

      // random traffic
      for (int i = 0; i < 600; i++) begin
         logic [15:0] a;
         int k;
         k = $urandom_range(0, 9);
         a = 16'($urandom);
         if (k < 4) wr({1'b0, a[14:0]}, 8'($urandom));
         else if (k < 6) wr({3'b101, a[12:0]}, 8'($urandom));
         else if (k < 8) rd({1'b0, a[14:0]}, "R6");
         else rd({3'b101, a[12:0]}, "R7");
      end

      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
   end
endmodule